// File: doc/BRIEF.md
# Mask-Driven Vector Compress

This block takes a source vector and a per-element select mask. It packs the selected elements, in ascending index order, into the lowest positions of a result vector. It reports how many elements were selected. It also builds a contiguous write-enable that covers only the packed prefix. Elements are either 8 or 16 bits wide, chosen per operation, and the vector width is a parameter given in bytes.

The packed prefix can be used in two ways:
- As a register update. A merged result is produced: packed elements sit below the count, and above it the old destination is kept (merge) or cleared (zero).
- As a partial store. The byte-granular enable marks exactly the bytes a memory write may touch, and every byte beyond the packed prefix is left alone.

Results are registered. They appear one clock after the request strobe and hold until the next request.

Top module: `vec_compress`

## Requirements
- R1: In byte mode (`word_mode_i`=0), `mask_i` bit j selects byte element j. Selected elements appear in `data_o` at positions 0, 1, 2, ... in ascending source index order.
- R2: In word mode (`word_mode_i`=1), element j is bytes 2j and 2j+1 (little-endian), and only `mask_i` bits 0 to N/2-1 are used. Mask bits at N/2 and above have no effect on any output.
- R3: `count_o` equals the number of active mask bits, in elements, as a binary value.
- R4: `wen_o` bit i is set exactly when i < `count_o` (element-granular thermometer, (1<<k)-1).
- R5: `byte_en_o` sets exactly the low k bytes in byte mode and the low 2k bytes in word mode.
- R6: All bytes of `data_o` at or above the packed prefix are zero.
- R7: `reg_o` equals `data_o` inside the packed prefix. Above it, `reg_o` equals `dst_i` when `zero_mode_i`=0 and zero when `zero_mode_i`=1.
- R8: A mask with no active bits gives `count_o`=0 and all-zero `wen_o`, `byte_en_o` and `data_o`.
- R9: Outputs update on the clock edge where `valid_i` is high, and `valid_o` is high in the following cycle. When `valid_i` is low, the data outputs hold and `valid_o` drops.
- R10: While `rst_ni` is low, `valid_o` and every data output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe; captures a new operation |
| word_mode_i | input | 1 | 0: 8-bit elements, 1: 16-bit elements |
| zero_mode_i | input | 1 | 0: merge old destination above prefix, 1: zero it |
| mask_i | input | VEC_BYTES | Per-element select mask |
| src_i | input | 8*VEC_BYTES | Source vector |
| dst_i | input | 8*VEC_BYTES | Old destination contents for merge |
| valid_o | output | 1 | Result valid |
| count_o | output | $clog2(VEC_BYTES+1) | Number of packed elements |
| wen_o | output | VEC_BYTES | Element write-enable thermometer |
| byte_en_o | output | VEC_BYTES | Byte write-enable for partial store |
| data_o | output | 8*VEC_BYTES | Packed result, zero above prefix |
| reg_o | output | 8*VEC_BYTES | Merged or zeroed register result |

## Verification
The assertions check the following on every cycle:
- the enable masks stay thermometers whose population matches the count;
- the count matches the popcount of the captured mask, with the high half ignored in word mode;
- the packed data stays zero above the prefix;
- the one-cycle valid latency holds, and results hold while idle.

The assertions cannot show that the right source elements land in the right slots in order, or that the merge and zero rules pick the correct bytes. The bench shows those by sweeping every mask in both element sizes and both fill modes, against an arithmetic model.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    FILL_MERGE = 1'b0,
    FILL_ZERO  = 1'b1
  } fill_e;

  typedef enum logic {
    ELEM_BYTE = 1'b0,
    ELEM_WORD = 1'b1
  } elem_e;
endpackage

// File: rtl/vcmp_lane_map.sv
module vcmp_lane_map
  import vcmp_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 16,
  localparam int unsigned CNT_W = $clog2(VEC_BYTES + 1)
) (
  input  logic                 word_mode_i,
  input  logic [VEC_BYTES-1:0] mask_i,
  output logic [VEC_BYTES-1:0] lane_mask_o,
  output logic [CNT_W-1:0]     lane_cnt_o,
  output logic [CNT_W-1:0]     elem_cnt_o
);
  elem_e esize;
  assign esize = elem_e'(word_mode_i);

  // word mode replicates each low-half mask bit onto a byte pair
  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_lane
    assign lane_mask_o[b] = (esize == ELEM_WORD) ? mask_i[b/2] : mask_i[b];
  end

  always_comb begin
    lane_cnt_o = '0;
    for (int b = 0; b < VEC_BYTES; b++) begin
      lane_cnt_o = lane_cnt_o + CNT_W'(lane_mask_o[b]);
    end
  end

  assign elem_cnt_o = (esize == ELEM_WORD) ? (lane_cnt_o >> 1) : lane_cnt_o;
endmodule

// File: rtl/vcmp_pack.sv
module vcmp_pack
  import vcmp_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 16,
  localparam int unsigned CNT_W  = $clog2(VEC_BYTES + 1),
  localparam int unsigned DATA_W = VEC_BYTES * BYTE_W
) (
  input  logic [VEC_BYTES-1:0] lane_mask_i,
  input  logic [DATA_W-1:0]    src_i,
  output logic [DATA_W-1:0]    packed_o
);
  // destination slot of each source lane = active lanes below it
  logic [CNT_W-1:0] slot [VEC_BYTES];

  always_comb begin
    slot[0] = '0;
    for (int j = 1; j < VEC_BYTES; j++) begin
      slot[j] = slot[j-1] + CNT_W'(lane_mask_i[j-1]);
    end
  end

  for (genvar i = 0; i < VEC_BYTES; i++) begin : g_out
    logic [BYTE_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = i; j < VEC_BYTES; j++) begin
        if (lane_mask_i[j] && slot[j] == CNT_W'(i)) begin
          acc = acc | src_i[j*BYTE_W +: BYTE_W];
        end
      end
    end
    assign packed_o[i*BYTE_W +: BYTE_W] = acc;
  end
endmodule

// File: rtl/vcmp_fill.sv
module vcmp_fill
  import vcmp_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 16,
  localparam int unsigned CNT_W  = $clog2(VEC_BYTES + 1),
  localparam int unsigned DATA_W = VEC_BYTES * BYTE_W
) (
  input  logic                 zero_mode_i,
  input  logic [CNT_W-1:0]     elem_cnt_i,
  input  logic [CNT_W-1:0]     lane_cnt_i,
  input  logic [DATA_W-1:0]    packed_i,
  input  logic [DATA_W-1:0]    dst_i,
  output logic [VEC_BYTES-1:0] wen_o,
  output logic [VEC_BYTES-1:0] byte_en_o,
  output logic [DATA_W-1:0]    merged_o
);
  fill_e fill;
  assign fill = fill_e'(zero_mode_i);

  for (genvar i = 0; i < VEC_BYTES; i++) begin : g_th
    localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
    assign wen_o[i]     = IDX < elem_cnt_i;
    assign byte_en_o[i] = IDX < lane_cnt_i;
    assign merged_o[i*BYTE_W +: BYTE_W] =
        byte_en_o[i]        ? packed_i[i*BYTE_W +: BYTE_W] :
        (fill == FILL_ZERO) ? '0 : dst_i[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/vec_compress.sv
module vec_compress
  import vcmp_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 16,
  localparam int unsigned CNT_W  = $clog2(VEC_BYTES + 1),
  localparam int unsigned DATA_W = VEC_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 word_mode_i,
  input  logic                 zero_mode_i,
  input  logic [VEC_BYTES-1:0] mask_i,
  input  logic [DATA_W-1:0]    src_i,
  input  logic [DATA_W-1:0]    dst_i,
  output logic                 valid_o,
  output logic [CNT_W-1:0]     count_o,
  output logic [VEC_BYTES-1:0] wen_o,
  output logic [VEC_BYTES-1:0] byte_en_o,
  output logic [DATA_W-1:0]    data_o,
  output logic [DATA_W-1:0]    reg_o
);
  logic [VEC_BYTES-1:0] lane_mask;
  logic [CNT_W-1:0]     lane_cnt, elem_cnt;
  logic [DATA_W-1:0]    packed_d, merged_d;
  logic [VEC_BYTES-1:0] wen_d, be_d;

  vcmp_lane_map #(.VEC_BYTES(VEC_BYTES)) u_map (
    .word_mode_i (word_mode_i),
    .mask_i      (mask_i),
    .lane_mask_o (lane_mask),
    .lane_cnt_o  (lane_cnt),
    .elem_cnt_o  (elem_cnt)
  );

  vcmp_pack #(.VEC_BYTES(VEC_BYTES)) u_pack (
    .lane_mask_i (lane_mask),
    .src_i       (src_i),
    .packed_o    (packed_d)
  );

  vcmp_fill #(.VEC_BYTES(VEC_BYTES)) u_fill (
    .zero_mode_i (zero_mode_i),
    .elem_cnt_i  (elem_cnt),
    .lane_cnt_i  (lane_cnt),
    .packed_i    (packed_d),
    .dst_i       (dst_i),
    .wen_o       (wen_d),
    .byte_en_o   (be_d),
    .merged_o    (merged_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      count_o   <= '0;
      wen_o     <= '0;
      byte_en_o <= '0;
      data_o    <= '0;
      reg_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        count_o   <= elem_cnt;
        wen_o     <= wen_d;
        byte_en_o <= be_d;
        data_o    <= packed_d;
        reg_o     <= merged_d;
      end
    end
  end
endmodule

// File: rtl/vec_compress_checker.sv
module vec_compress_checker
  import vcmp_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 16,
  localparam int unsigned CNT_W  = $clog2(VEC_BYTES + 1),
  localparam int unsigned DATA_W = VEC_BYTES * BYTE_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 word_mode_i,
  input logic [VEC_BYTES-1:0] mask_i,
  input logic                 valid_o,
  input logic [CNT_W-1:0]     count_o,
  input logic [VEC_BYTES-1:0] wen_o,
  input logic [VEC_BYTES-1:0] byte_en_o,
  input logic [DATA_W-1:0]    data_o
);
  localparam logic [VEC_BYTES-1:0] LOW_HALF =
      {{(VEC_BYTES - VEC_BYTES/2){1'b0}}, {(VEC_BYTES/2){1'b1}}};

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  logic [DATA_W-1:0] be_bits;
  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_bits
    assign be_bits[b*BYTE_W +: BYTE_W] = {BYTE_W{byte_en_o[b]}};
  end

  logic [VEC_BYTES:0] wen_ext, be_ext;
  assign wen_ext = {1'b0, wen_o};
  assign be_ext  = {1'b0, byte_en_o};

  p_valid_delay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> valid_o == $past(valid_i));

  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(count_o) && $stable(wen_o) && $stable(byte_en_o) && $stable(data_o));

  p_count_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && valid_o |-> count_o == ($past(word_mode_i)
        ? CNT_W'($countones($past(mask_i) & LOW_HALF))
        : CNT_W'($countones($past(mask_i)))));

  p_wen_thermo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wen_ext + 1'b1) & wen_ext) == '0);

  p_wen_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wen_o) == int'(count_o));

  p_be_thermo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((be_ext + 1'b1) & be_ext) == '0);

  p_be_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && valid_o |-> $countones(byte_en_o) ==
        ($past(word_mode_i) ? 2 * int'(count_o) : int'(count_o)));

  p_data_zero_above_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o & ~be_bits) == '0);

  p_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == '0 |-> wen_o == '0 && byte_en_o == '0 && data_o == '0);
endmodule

bind vec_compress vec_compress_checker #(.VEC_BYTES(VEC_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .word_mode_i (word_mode_i),
  .mask_i      (mask_i),
  .valid_o     (valid_o),
  .count_o     (count_o),
  .wen_o       (wen_o),
  .byte_en_o   (byte_en_o),
  .data_o      (data_o)
);

// File: tb/vec_compress_bench.sv
module vec_compress_bench;
  localparam int unsigned NB      = 8;
  localparam int unsigned DW      = NB * 8;
  localparam int unsigned CW      = $clog2(NB + 1);
  localparam time         CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0, word_mode_i = 1'b0, zero_mode_i = 1'b0;
  logic [NB-1:0] mask_i = '0;
  logic [DW-1:0] src_i = '0, dst_i = '0;
  logic          valid_o;
  logic [CW-1:0] count_o;
  logic [NB-1:0] wen_o, byte_en_o;
  logic [DW-1:0] data_o, reg_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;

  vec_compress #(.VEC_BYTES(NB)) u_vec_compress (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .word_mode_i(word_mode_i),
    .zero_mode_i(zero_mode_i), .mask_i(mask_i), .src_i(src_i), .dst_i(dst_i),
    .valid_o(valid_o), .count_o(count_o), .wen_o(wen_o), .byte_en_o(byte_en_o),
    .data_o(data_o), .reg_o(reg_o)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h (mask=%h word=%0d zero=%0d)",
               req, got, exp, mask_i, word_mode_i, zero_mode_i);
    end
  endtask

  logic [DW-1:0] e_data, e_reg;
  logic [NB-1:0] e_wen, e_be;
  int            e_k;

  task automatic model();
    int esz, nel, bytes;
    esz = word_mode_i ? 2 : 1;
    nel = NB / esz;
    e_data = '0;
    e_k = 0;
    for (int j = 0; j < nel; j++) begin
      if (mask_i[j]) begin
        for (int b = 0; b < esz; b++)
          e_data[(e_k*esz+b)*8 +: 8] = src_i[(j*esz+b)*8 +: 8];
        e_k++;
      end
    end
    bytes = e_k * esz;
    e_wen = NB'((64'd1 << e_k) - 1);
    e_be  = NB'((64'd1 << bytes) - 1);
    for (int b = 0; b < NB; b++)
      e_reg[b*8 +: 8] = (b < bytes) ? e_data[b*8 +: 8] : (zero_mode_i ? 8'h00 : dst_i[b*8 +: 8]);
  endtask

  task automatic run_one(input logic wm, input logic zm, input logic [NB-1:0] m);
    word_mode_i = wm; zero_mode_i = zm; mask_i = m;
    src_i = {$urandom, $urandom}; dst_i = {$urandom, $urandom};
    valid_i = 1'b1;
    model();
    @(negedge clk);
    check(wm ? "R2 data" : "R1 data", data_o, e_data);
    check("R3 count", 64'(count_o), 64'(e_k));
    check("R4 wen", 64'(wen_o), 64'(e_wen));
    check("R5 byte_en", 64'(byte_en_o), 64'(e_be));
    check("R7 reg", reg_o, e_reg);
    check("R9 valid", 64'(valid_o), 64'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] hold_d;
    logic [CW-1:0] hold_c;
    // R10: reset holds outputs low even with a request present
    valid_i = 1'b1; mask_i = '1; src_i = '1;
    repeat (3) @(negedge clk);
    check("R10 valid", 64'(valid_o), 64'd0);
    check("R10 data", data_o | reg_o, 64'd0);
    check("R10 enables", 64'({count_o, wen_o, byte_en_o}), 64'd0);
    valid_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // Exhaustive sweep R1..R7
    for (int wm = 0; wm < 2; wm++)
      for (int zm = 0; zm < 2; zm++)
        for (int m = 0; m < (1 << NB); m++)
          run_one(wm[0], zm[0], NB'(m));

    // R6: known pattern, bytes above prefix zero
    run_one(1'b0, 1'b0, 8'b1010_0100);
    check("R6 upper zero", data_o & ~64'h0000_0000_00FF_FFFF, 64'd0);

    // R8: empty mask
    run_one(1'b0, 1'b0, 8'h00);
    check("R8 empty", 64'({count_o, wen_o, byte_en_o}) | data_o, 64'd0);
    check("R8 reg merge", reg_o, dst_i);

    // R2: upper mask bits ignored in word mode
    run_one(1'b1, 1'b1, 8'hF0);
    check("R2 upper ignored count", 64'(count_o), 64'd0);
    check("R2 upper ignored data", data_o | reg_o, 64'd0);

    // R9: idle cycle holds outputs
    run_one(1'b0, 1'b0, 8'h5A);
    hold_d = data_o; hold_c = count_o;
    valid_i = 1'b0; mask_i = 8'hFF; src_i = ~src_i;
    @(negedge clk);
    check("R9 valid drop", 64'(valid_o), 64'd0);
    check("R9 hold data", data_o, hold_d);
    check("R9 hold count", 64'(count_o), 64'(hold_c));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule